// File: doc/BRIEF.md
# Address-Match Port Contention Arbiter

This block sits beside a two-port memory and watches the chip enable and address of each port. When both ports are enabled and point at the same word, the port whose request came later is told to wait. The block pulls that port's active-low BUSY line low and blocks its write strobe. When both requests show up together, a fixed rule picks the right port. The two BUSY lines are never low together.

The arbiter samples both ports on a clock. At each edge it registers each port's enable and address, so a port counts as having moved when it was disabled at the previous edge or its address has changed since then. When a match first appears, the decision is taken from which ports moved at that edge. The decision holds while the match lasts and is dropped at the first edge where the match is gone.

A mode input picks master or slave operation. In master mode the block drives both BUSY outputs with push-pull levels and gates writes from its own decision. In slave mode both BUSY outputs stay high. An external active-low BUSY input per port then decides which write strobes are blocked.

Top module: `port_contention_arbiter`

## Requirements
- R1: After reset, and with no match since, both BUSY outputs (active low) read 1.
- R2: When both ports are enabled (enable input 0) with different addresses, both BUSY outputs stay 1.
- R3: When either port's enable input is 1, both BUSY outputs are 1 one cycle later, whatever the addresses.
- R4: When the right port is already enabled at an address and the left port becomes enabled at that address or moves to it, the left BUSY output reads 0 and the right BUSY output reads 1 from the cycle after that edge.
- R5: When the left port is already enabled at an address and the right port arrives at it, the right BUSY output reads 0 and the left BUSY output reads 1 from the cycle after that edge.
- R6: When both ports move onto a matching address at the same sampling edge, the right BUSY output reads 0 and the left reads 1.
- R7: The left and right BUSY outputs are never 0 at the same time.
- R8: A BUSY output returns to 1 one cycle after the sampling edge at which the match has ended.
- R9: While the match continues, the BUSY decision is held, even if both addresses change together to a new common value.
- R10: In master mode (mode input 1), a port's gated write strobe (active low) is forced to 1 while that port's BUSY output is 0. Otherwise it equals the port's write strobe input.
- R11: In slave mode (mode input 0), both BUSY outputs are 1. A port's gated write strobe is forced to 1 while that port's external BUSY input is 0, and otherwise follows its write strobe input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 selects master mode, 0 selects slave mode |
| l_ce_ni | input | 1 | Left port enable, active low |
| l_addr_i | input | ADDR_W | Left port address |
| l_we_ni | input | 1 | Left port write strobe, active low |
| l_busy_ni | input | 1 | External BUSY for the left port in slave mode, active low |
| r_ce_ni | input | 1 | Right port enable, active low |
| r_addr_i | input | ADDR_W | Right port address |
| r_we_ni | input | 1 | Right port write strobe, active low |
| r_busy_ni | input | 1 | External BUSY for the right port in slave mode, active low |
| l_busy_no | output | 1 | Left BUSY, active low, push-pull |
| r_busy_no | output | 1 | Right BUSY, active low, push-pull |
| l_we_no | output | 1 | Gated left write strobe, active low |
| r_we_no | output | 1 | Gated right write strobe, active low |

## Verification
The hardest case to reach is a change of address that keeps the match while both ports move. Such a change must leave the existing decision alone and must not be read as a new arrival. The stimulus table first sets up a simultaneous arrival. It then moves both addresses together at one edge to a new shared value and expects the earlier decision to hold. It also stages arrivals from each side one cycle apart, both by a fresh enable and by an address change onto the other port's address. Directed steps then put a write strobe on both ports while one port is busy, in master mode and in slave mode.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    BUSY_LEFT = 2'd1,
    BUSY_RIGHT = 2'd2
  } arb_state_e;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned IDX_L = 0;
  localparam int unsigned IDX_R = 1;
endpackage

// File: rtl/arb_port_tracker.sv
module arb_port_tracker #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              moved_o
);
  logic              ce_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b1;
      addr_q <= '0;
    end else begin
      ce_q   <= ce_ni;
      addr_q <= addr_i;
    end
  end

  // moved: was idle last edge, or now points elsewhere
  assign moved_o = ce_q | (addr_q != addr_i);
endmodule

// File: rtl/arb_decide.sv
module arb_decide
  import arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [NUM_PORTS-1:0]                 ce_ni,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]     addr_i,
  input  logic [NUM_PORTS-1:0]                 moved_i,
  output logic                                 match_o,
  output logic [NUM_PORTS-1:0]                 busy_o
);
  arb_state_e state_q, state_d;

  assign match_o = ~ce_ni[IDX_L] & ~ce_ni[IDX_R] & (addr_i[IDX_L] == addr_i[IDX_R]);

  always_comb begin
    state_d = state_q;
    if (!match_o) begin
      state_d = OWN_NONE;
    end else if (state_q == OWN_NONE) begin
      // later arrival gets busy; tie or ambiguity goes to the right port
      if (moved_i[IDX_L] && !moved_i[IDX_R]) state_d = BUSY_LEFT;
      else                                   state_d = BUSY_RIGHT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= OWN_NONE;
    else         state_q <= state_d;
  end

  assign busy_o[IDX_L] = (state_q == BUSY_LEFT);
  assign busy_o[IDX_R] = (state_q == BUSY_RIGHT);

  AST_HOLD_WHILE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && state_q != OWN_NONE) |=> ($past(state_q) == state_q)) else $error("hold"); // R9

  AST_TIE_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && state_q == OWN_NONE && moved_i[IDX_L] && moved_i[IDX_R]) |=> busy_o[IDX_R]) else $error("tie"); // R6

  AST_LEFT_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && state_q == OWN_NONE && moved_i[IDX_L] && !moved_i[IDX_R]) |=> busy_o[IDX_L]) else $error("left late"); // R4
endmodule

// File: rtl/arb_write_gate.sv
module arb_write_gate (
  input  logic master_i,
  input  logic busy_int_i,
  input  logic busy_ext_ni,
  input  logic we_ni,
  output logic busy_no,
  output logic we_no
);
  logic blocked;

  assign blocked = master_i ? busy_int_i : ~busy_ext_ni;
  assign busy_no = master_i ? ~busy_int_i : 1'b1;
  assign we_no   = we_ni | blocked;

  always_comb begin
    if (!blocked) AST_PASS_THROUGH: assert (we_no == we_ni) else $error("pass"); // R10
  end
endmodule

// File: rtl/port_contention_arbiter.sv
module port_contention_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_ce_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_we_ni,
  input  logic              l_busy_ni,
  input  logic              r_ce_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_we_ni,
  input  logic              r_busy_ni,
  output logic              l_busy_no,
  output logic              r_busy_no,
  output logic              l_we_no,
  output logic              r_we_no
);
  logic [NUM_PORTS-1:0]             ce_n;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr;
  logic [NUM_PORTS-1:0]             we_n;
  logic [NUM_PORTS-1:0]             busy_ext_n;
  logic [NUM_PORTS-1:0]             moved;
  logic [NUM_PORTS-1:0]             busy_int;
  logic [NUM_PORTS-1:0]             busy_n;
  logic [NUM_PORTS-1:0]             we_gated_n;
  logic                             match;

  assign ce_n[IDX_L]       = l_ce_ni;
  assign ce_n[IDX_R]       = r_ce_ni;
  assign addr[IDX_L]       = l_addr_i;
  assign addr[IDX_R]       = r_addr_i;
  assign we_n[IDX_L]       = l_we_ni;
  assign we_n[IDX_R]       = r_we_ni;
  assign busy_ext_n[IDX_L] = l_busy_ni;
  assign busy_ext_n[IDX_R] = r_busy_ni;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    arb_port_tracker #(.ADDR_W(ADDR_W)) i_tracker (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ce_ni  (ce_n[p]),
      .addr_i (addr[p]),
      .moved_o(moved[p])
    );

    arb_write_gate i_gate (
      .master_i   (master_i),
      .busy_int_i (busy_int[p]),
      .busy_ext_ni(busy_ext_n[p]),
      .we_ni      (we_n[p]),
      .busy_no    (busy_n[p]),
      .we_no      (we_gated_n[p])
    );
  end

  arb_decide #(.ADDR_W(ADDR_W)) i_decide (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_ni  (ce_n),
    .addr_i (addr),
    .moved_i(moved),
    .match_o(match),
    .busy_o (busy_int)
  );

  assign l_busy_no = busy_n[IDX_L];
  assign r_busy_no = busy_n[IDX_R];
  assign l_we_no   = we_gated_n[IDX_L];
  assign r_we_no   = we_gated_n[IDX_R];

  AST_NEVER_BOTH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_busy_no || r_busy_no)) else $error("both busy"); // R7

  AST_RELEASE_AFTER_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match |=> (l_busy_no && r_busy_no)) else $error("release"); // R8

  AST_SLAVE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (l_busy_no && r_busy_no)) else $error("slave"); // R11

  AST_WE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !l_busy_no) |-> l_we_no) else $error("we block"); // R10
endmodule

// File: tb/test_port_contention_arbiter.sv
module test_port_contention_arbiter;
  localparam int unsigned AW = 13;

  typedef struct packed {
    logic          l_ce;
    logic [AW-1:0] l_a;
    logic          r_ce;
    logic [AW-1:0] r_a;
    logic          exp_l;
    logic          exp_r;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 13'd0,  1'b1, 13'd0,  1'b1, 1'b1}, // R3 idle
    '{1'b0, 13'd5,  1'b1, 13'd0,  1'b1, 1'b1}, // R3 one enabled
    '{1'b0, 13'd5,  1'b0, 13'd5,  1'b1, 1'b0}, // R5 right later
    '{1'b0, 13'd5,  1'b0, 13'd5,  1'b1, 1'b0}, // R9 held
    '{1'b0, 13'd5,  1'b0, 13'd6,  1'b1, 1'b1}, // R8 R2 released
    '{1'b0, 13'd5,  1'b0, 13'd5,  1'b1, 1'b0}, // R5 right moves onto left
    '{1'b0, 13'd7,  1'b0, 13'd5,  1'b1, 1'b1}, // R2
    '{1'b0, 13'd5,  1'b0, 13'd5,  1'b0, 1'b1}, // R4 left moves onto right
    '{1'b1, 13'd5,  1'b0, 13'd5,  1'b1, 1'b1}, // R3 R8
    '{1'b1, 13'd9,  1'b1, 13'd9,  1'b1, 1'b1}, // R3
    '{1'b0, 13'd9,  1'b0, 13'd9,  1'b1, 1'b0}, // R6 tie
    '{1'b0, 13'd10, 1'b0, 13'd10, 1'b1, 1'b0}, // R9 joint move
    '{1'b1, 13'd10, 1'b1, 13'd10, 1'b1, 1'b1}, // R8
    '{1'b0, 13'd3,  1'b0, 13'd4,  1'b1, 1'b1}, // R2
    '{1'b0, 13'd3,  1'b0, 13'd3,  1'b1, 1'b0}  // R5
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic master_i = 1'b1;
  logic l_ce_ni = 1'b1, r_ce_ni = 1'b1;
  logic [AW-1:0] l_addr_i = '0, r_addr_i = '0;
  logic l_we_ni = 1'b1, r_we_ni = 1'b1;
  logic l_busy_ni = 1'b1, r_busy_ni = 1'b1;
  logic l_busy_no, r_busy_no, l_we_no, r_we_no;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  port_contention_arbiter #(.ADDR_W(AW)) i_port_contention_arbiter (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master_i),
    .l_ce_ni(l_ce_ni), .l_addr_i(l_addr_i), .l_we_ni(l_we_ni), .l_busy_ni(l_busy_ni),
    .r_ce_ni(r_ce_ni), .r_addr_i(r_addr_i), .r_we_ni(r_we_ni), .r_busy_ni(r_busy_ni),
    .l_busy_no(l_busy_no), .r_busy_no(r_busy_no), .l_we_no(l_we_no), .r_we_no(r_we_no)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic lc, input logic [AW-1:0] la, input logic rc, input logic [AW-1:0] ra);
    l_ce_ni = lc; l_addr_i = la; r_ce_ni = rc; r_addr_i = ra;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset l_busy", l_busy_no, 1'b1);
    chk("R1 reset r_busy", r_busy_no, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after reset l_busy", l_busy_no, 1'b1);
    chk("R1 after reset r_busy", r_busy_no, 1'b1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].l_ce, VEC[i].l_a, VEC[i].r_ce, VEC[i].r_a);
      @(negedge clk);
      chk($sformatf("vec%0d l_busy", i), l_busy_no, VEC[i].exp_l);
      chk($sformatf("vec%0d r_busy", i), r_busy_no, VEC[i].exp_r);
      chk($sformatf("R7 vec%0d not both", i), l_busy_no | r_busy_no, 1'b1);
    end

    // R10 right busy now: right write blocked, left passes
    l_we_ni = 1'b0; r_we_ni = 1'b0;
    #1;
    chk("R10 right write blocked", r_we_no, 1'b1);
    chk("R10 left write passes", l_we_no, 1'b0);
    // R10 left busy case
    @(negedge clk);
    l_we_ni = 1'b1; r_we_ni = 1'b1;
    drive(1'b1, 13'd0, 1'b1, 13'd0);
    @(negedge clk);
    drive(1'b1, 13'd0, 1'b0, 13'd20);
    @(negedge clk);
    drive(1'b0, 13'd20, 1'b0, 13'd20);
    @(negedge clk);
    chk("R4 fresh left enable busy", l_busy_no, 1'b0);
    l_we_ni = 1'b0; r_we_ni = 1'b0;
    #1;
    chk("R10 left write blocked", l_we_no, 1'b1);
    chk("R10 right write passes", r_we_no, 1'b0);
    l_we_ni = 1'b1;
    #1;
    chk("R10 idle strobe stays high", l_we_no, 1'b1);

    // R11 slave mode: outputs idle, external busy gates writes
    @(negedge clk);
    master_i = 1'b0;
    l_we_ni = 1'b0; r_we_ni = 1'b0;
    l_busy_ni = 1'b0; r_busy_ni = 1'b1;
    #1;
    chk("R11 slave l_busy out", l_busy_no, 1'b1);
    chk("R11 slave r_busy out", r_busy_no, 1'b1);
    chk("R11 slave left blocked", l_we_no, 1'b1);
    chk("R11 slave right passes", r_we_no, 1'b0);
    l_busy_ni = 1'b1; r_busy_ni = 1'b0;
    #1;
    chk("R11 slave left passes", l_we_no, 1'b0);
    chk("R11 slave right blocked", r_we_no, 1'b1);

    // R8 back in master: end match, release next cycle
    @(negedge clk);
    master_i = 1'b1; r_busy_ni = 1'b1; l_we_ni = 1'b1; r_we_ni = 1'b1;
    drive(1'b0, 13'd20, 1'b0, 13'd21);
    @(negedge clk);
    chk("R8 left released", l_busy_no, 1'b1);
    chk("R8 right released", r_busy_no, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule